// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Write-Cycle Output

This block is a true dual-port synchronous RAM. The two ports are fully symmetric. Each port has its own clock, a clock-enable, a write-enable, an address, a data input, a data output and a synchronous output force input. Either port can read or write any location. Each port registers its output on its own clock's rising edge.

For each port, a parameter decides what the output register shows when that port writes. There are three choices:
- **write-first**: the output shows the word being written.
- **read-first**: the output shows the word the location held before the write.
- **no-change**: the output keeps its previous value.

A synchronous force input loads the output register with a per-port reset value. It does not touch the stored words.

The total port width is a parameter taken from the set 1, 2, 4, 9, 18 and 36. The three widest settings split the word into data bits and 1, 2 or 4 parity bits. The parity bits travel on their own input and output buses. The parity bits form the top bits of the stored word.

The block has no reset input. The output registers power up at their reset values. If both ports write the same address on the same edge, the stored result is undefined. A read on one port of an address that the other port writes on the same edge is also undefined.

Internally, each port decodes one operation per edge:
- **OP_HOLD**: enable is low.
- **OP_FORCE**: enable is high and force is high.
- **OP_WRITE**: enable is high, force is low and write is high.
- **OP_READ**: enable is high, force is low and write is low.

The output register follows the operation decoded on that edge. There is no longer-lived state.

Top module: `dp_ram_wm`

## Requirements
- R1: With enable high, force low and write low, a rising edge loads the port's output with the stored word at the presented address.
- R2: With enable and write high, a rising edge stores the input word, including parity, at the address. A later read from either port returns that word.
- R3: On a write-first port, a write edge (force low) loads the output with the word being written.
- R4: On a read-first port, a write edge (force low) loads the output with the word the location held before that edge.
- R5: On a no-change port, a write edge (force low) leaves the output unchanged.
- R6: With enable low, an edge performs no write, no output update and no force, whatever the write and force inputs are.
- R7: With enable and force high, an edge loads that port's output with its reset value. The stored contents and the other port's output are not affected.
- R8: When force and write are both high with enable, the force wins on the output, and the write still stores the word.
- R9: Both output registers hold their reset values from power-up until the first enabled edge.
- R10: For port widths 9, 18 and 36, the parity bus carries the top 1, 2 or 4 bits of the word. For widths 1, 2 and 4 the parity output is always 0 and the parity input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| srst_a | input | 1 | Port A synchronous output force |
| addr_a | input | ADDR_W | Port A address |
| din_a | input | DATA_W | Port A write data |
| dinp_a | input | PAR_PORT_W | Port A write parity |
| dout_a | output | DATA_W | Port A registered read data |
| doutp_a | output | PAR_PORT_W | Port A registered parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| srst_b | input | 1 | Port B synchronous output force |
| addr_b | input | ADDR_W | Port B address |
| din_b | input | DATA_W | Port B write data |
| dinp_b | input | PAR_PORT_W | Port B write parity |
| dout_b | output | DATA_W | Port B registered read data |
| doutp_b | output | PAR_PORT_W | Port B registered parity |

## Verification
Every output result is due on the first rising edge after its inputs are presented. That covers reads, write-mode updates, forces and holds. A stored word becomes visible to reads from either port on the next edge after the write edge.

The bench drives inputs on the falling edge. It computes each port's expected output from a model of the memory as it stood before the edge. It compares the outputs on the next falling edge, which is exactly one register stage later.

Expected values that depend on never-written locations are tracked as unknown and are not compared. Stimulus keeps the two ports off a shared address whenever either port writes.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_FORCE = 2'd3
    } op_e;

    // parity bits carried by a given total port width
    function automatic int par_bits(input int width);
        if (width == 36) return 4;
        if (width == 18) return 2;
        if (width == 9)  return 1;
        return 0;
    endfunction

endpackage

// File: rtl/dpr_bank.sv
// One storage bank with a single write port and two asynchronous read taps.
// Two banks combined by XOR give a true dual-write memory without a shared writer.
module dpr_bank #(
    parameter int W  = 18,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_word,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_word_a,
    output logic [W-1:0]  rd_word_b
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_word;
        end
    end

    assign rd_word_a = cells[rd_addr_a];
    assign rd_word_b = cells[rd_addr_b];

endmodule

// File: rtl/dpr_port.sv
// Per-port output controller: decodes the operation on each edge and
// updates the output register according to the port's write mode.
module dpr_port
    import dpr_pkg::*;
#(
    parameter int           W      = 18,
    parameter wmode_e       MODE   = WM_WRITE_FIRST,
    parameter logic [W-1:0] RSTVAL = '0
) (
    input  logic         clk,
    input  logic         en,
    input  logic         we,
    input  logic         srst,
    input  logic [W-1:0] wr_word,
    input  logic [W-1:0] old_word,
    output logic [W-1:0] dout
);
    op_e          op_now;
    logic [W-1:0] dout_q = RSTVAL;
    logic [W-1:0] dout_d;

    // operation decode: force outranks read and write on the output
    always_comb begin
        if (!en) begin
            op_now = OP_HOLD;
        end else if (srst) begin
            op_now = OP_FORCE;
        end else if (we) begin
            op_now = OP_WRITE;
        end else begin
            op_now = OP_READ;
        end
    end

    // output selection
    always_comb begin
        dout_d = dout_q;
        unique case (op_now)
            OP_HOLD:  dout_d = dout_q;
            OP_FORCE: dout_d = RSTVAL;
            OP_READ:  dout_d = old_word;
            OP_WRITE: begin
                unique case (MODE)
                    WM_WRITE_FIRST: dout_d = wr_word;
                    WM_READ_FIRST:  dout_d = old_word;
                    default:        dout_d = dout_q;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        dout_q <= dout_d;
    end

    assign dout = dout_q;

endmodule

// File: rtl/dp_ram_wm.sv
module dp_ram_wm
    import dpr_pkg::*;
#(
    parameter int                PORT_W   = 18,
    parameter int                ADDR_W   = 8,
    parameter wmode_e            MODE_A   = WM_WRITE_FIRST,
    parameter wmode_e            MODE_B   = WM_READ_FIRST,
    parameter logic [PORT_W-1:0] RSTVAL_A = '0,
    parameter logic [PORT_W-1:0] RSTVAL_B = '0,
    localparam int PAR_W      = par_bits(PORT_W),
    localparam int DATA_W     = PORT_W - PAR_W,
    localparam int PAR_PORT_W = (PAR_W == 0) ? 1 : PAR_W
) (
    input  logic                  clk_a,
    input  logic                  en_a,
    input  logic                  we_a,
    input  logic                  srst_a,
    input  logic [ADDR_W-1:0]     addr_a,
    input  logic [DATA_W-1:0]     din_a,
    input  logic [PAR_PORT_W-1:0] dinp_a,
    output logic [DATA_W-1:0]     dout_a,
    output logic [PAR_PORT_W-1:0] doutp_a,
    input  logic                  clk_b,
    input  logic                  en_b,
    input  logic                  we_b,
    input  logic                  srst_b,
    input  logic [ADDR_W-1:0]     addr_b,
    input  logic [DATA_W-1:0]     din_b,
    input  logic [PAR_PORT_W-1:0] dinp_b,
    output logic [DATA_W-1:0]     dout_b,
    output logic [PAR_PORT_W-1:0] doutp_b
);
    logic [PORT_W-1:0] word_in_a,  word_in_b;
    logic [PORT_W-1:0] word_out_a, word_out_b;
    logic [PORT_W-1:0] a_at_a, a_at_b, b_at_a, b_at_b;
    logic [PORT_W-1:0] old_a, old_b;

    // word assembly: parity occupies the top bits
    generate
        if (PAR_W > 0) begin : g_par
            assign word_in_a = {dinp_a[PAR_W-1:0], din_a};
            assign word_in_b = {dinp_b[PAR_W-1:0], din_b};
            assign doutp_a   = word_out_a[PORT_W-1:DATA_W];
            assign doutp_b   = word_out_b[PORT_W-1:DATA_W];
        end else begin : g_nopar
            logic unused_par;
            assign unused_par = ^{dinp_a, dinp_b};
            assign word_in_a  = din_a;
            assign word_in_b  = din_b;
            assign doutp_a    = '0;
            assign doutp_b    = '0;
        end
    endgenerate

    // XOR-coded storage: stored word = bank_a ^ bank_b
    dpr_bank #(.W(PORT_W), .AW(ADDR_W)) u_bank_a (
        .clk       (clk_a),
        .wr_en     (en_a & we_a),
        .wr_addr   (addr_a),
        .wr_word   (word_in_a ^ b_at_a),
        .rd_addr_a (addr_a),
        .rd_addr_b (addr_b),
        .rd_word_a (a_at_a),
        .rd_word_b (a_at_b)
    );

    dpr_bank #(.W(PORT_W), .AW(ADDR_W)) u_bank_b (
        .clk       (clk_b),
        .wr_en     (en_b & we_b),
        .wr_addr   (addr_b),
        .wr_word   (word_in_b ^ a_at_b),
        .rd_addr_a (addr_a),
        .rd_addr_b (addr_b),
        .rd_word_a (b_at_a),
        .rd_word_b (b_at_b)
    );

    assign old_a = a_at_a ^ b_at_a;
    assign old_b = a_at_b ^ b_at_b;

    dpr_port #(.W(PORT_W), .MODE(MODE_A), .RSTVAL(RSTVAL_A)) u_port_a (
        .clk      (clk_a),
        .en       (en_a),
        .we       (we_a),
        .srst     (srst_a),
        .wr_word  (word_in_a),
        .old_word (old_a),
        .dout     (word_out_a)
    );

    dpr_port #(.W(PORT_W), .MODE(MODE_B), .RSTVAL(RSTVAL_B)) u_port_b (
        .clk      (clk_b),
        .en       (en_b),
        .we       (we_b),
        .srst     (srst_b),
        .wr_word  (word_in_b),
        .old_word (old_b),
        .dout     (word_out_b)
    );

    assign dout_a = word_out_a[DATA_W-1:0];
    assign dout_b = word_out_b[DATA_W-1:0];

endmodule

// File: rtl/dpr_chk.sv
module dpr_chk
    import dpr_pkg::*;
#(
    parameter int           W      = 18,
    parameter wmode_e       MODE   = WM_WRITE_FIRST,
    parameter logic [W-1:0] RSTVAL = '0,
    parameter int           PAR_W  = 2,
    parameter int           PP_W   = 2
) (
    input logic            clk,
    input logic            en,
    input logic            we,
    input logic            srst,
    input logic [W-1:0]    wr_word,
    input logic [W-1:0]    dout_word,
    input logic [PP_W-1:0] doutp
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // force (with or without a write) loads the reset value: R7, R8
    assert_force_value_R7: assert property (@(posedge clk) disable iff (!armed)
        (en && srst) |=> (dout_word == RSTVAL));

    // disabled edge leaves the output alone
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!armed)
        (!en) |=> $stable(dout_word));

    generate
        if (MODE == WM_WRITE_FIRST) begin : g_wf
            assert_write_first_R3: assert property (@(posedge clk) disable iff (!armed)
                (en && we && !srst) |=> (dout_word == $past(wr_word)));
        end
        if (MODE == WM_NO_CHANGE) begin : g_nc
            assert_no_change_R5: assert property (@(posedge clk) disable iff (!armed)
                (en && we && !srst) |=> $stable(dout_word));
        end
        if (PAR_W == 0) begin : g_np
            assert_parity_zero_R10: assert property (@(posedge clk) disable iff (!armed)
                en |=> (doutp == '0));
        end
    endgenerate

endmodule

bind dp_ram_wm dpr_chk #(
    .W(PORT_W), .MODE(MODE_A), .RSTVAL(RSTVAL_A), .PAR_W(PAR_W), .PP_W(PAR_PORT_W)
) u_chk_a (
    .clk(clk_a), .en(en_a), .we(we_a), .srst(srst_a),
    .wr_word(word_in_a), .dout_word(word_out_a), .doutp(doutp_a)
);

bind dp_ram_wm dpr_chk #(
    .W(PORT_W), .MODE(MODE_B), .RSTVAL(RSTVAL_B), .PAR_W(PAR_W), .PP_W(PAR_PORT_W)
) u_chk_b (
    .clk(clk_b), .en(en_b), .we(we_b), .srst(srst_b),
    .wr_word(word_in_b), .dout_word(word_out_b), .doutp(doutp_b)
);

// File: tb/dp_ram_wm_tb.sv
module dp_ram_wm_tb;
    import dpr_pkg::*;

    localparam logic [17:0] RST1A = 18'h25A3C;
    localparam logic [17:0] RST1B = 18'h10F0F;
    localparam logic [17:0] RST2A = 18'h9;
    localparam logic [17:0] RST2B = 18'h6;
    localparam int WF = 0, RF = 1, NC = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        en_a = 0, we_a = 0, srst_a = 0, en_b = 0, we_b = 0, srst_b = 0;
    logic [7:0]  addr_a = 0, addr_b = 0;
    logic [15:0] din_a = 0, din_b = 0;
    logic [1:0]  dinp_a = 0, dinp_b = 0;
    logic [15:0] dout1_a, dout1_b;
    logic [1:0]  doutp1_a, doutp1_b;
    logic [3:0]  dout2_a, dout2_b;
    logic        doutp2_a, doutp2_b;

    // main instance: 18-bit word (16 data + 2 parity), write-first / read-first
    dp_ram_wm #(.PORT_W(18), .ADDR_W(8), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST),
                .RSTVAL_A(RST1A), .RSTVAL_B(RST1B)) u_dut (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .srst_a(srst_a), .addr_a(addr_a),
        .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout1_a), .doutp_a(doutp1_a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .srst_b(srst_b), .addr_b(addr_b),
        .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout1_b), .doutp_b(doutp1_b));

    // narrow instance: 4-bit word, no parity, no-change / write-first
    dp_ram_wm #(.PORT_W(4), .ADDR_W(4), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST),
                .RSTVAL_A(RST2A[3:0]), .RSTVAL_B(RST2B[3:0])) u_nc (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .srst_a(srst_a), .addr_a(addr_a[3:0]),
        .din_a(din_a[3:0]), .dinp_a(dinp_a[0]), .dout_a(dout2_a), .doutp_a(doutp2_a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .srst_b(srst_b), .addr_b(addr_b[3:0]),
        .din_b(din_b[3:0]), .dinp_b(dinp_b[0]), .dout_b(dout2_b), .doutp_b(doutp2_b));

    int n_vec = 0, n_bad = 0;
    logic [17:0] m1 [256];
    bit          v1 [256];
    logic [17:0] m2 [16];
    bit          v2 [16];
    logic [17:0] e1a = RST1A, e1b = RST1B, e2a = RST2A, e2b = RST2B;
    bit          ev1a = 1, ev1b = 1, ev2a = 1, ev2b = 1;

    task automatic chk(input string tag, input string who, input logic [17:0] act,
                       input logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
        end
    endtask

    function automatic string tag_for(input int mode, input bit en, input bit we,
                                      input bit srst);
        if (!en) return "R6";
        if (srst) return we ? "R8" : "R7";
        if (!we) return "R1";
        if (mode == WF) return "R3";
        if (mode == RF) return "R4";
        return "R5";
    endfunction

    // next output of one port, from the requirements
    task automatic model_port(input int mode, input bit en, input bit we, input bit srst,
                              input logic [17:0] din, input logic [17:0] old, input bit oldv,
                              input logic [17:0] rst, inout logic [17:0] cur, inout bit curv);
        if (!en) return;
        if (srst) begin cur = rst; curv = 1; end
        else if (!we) begin cur = old; curv = oldv; end
        else if (mode == WF) begin cur = din; curv = 1; end
        else if (mode == RF) begin cur = old; curv = oldv; end
    endtask

    // called at a falling edge; drives, models, then compares one falling edge later
    task automatic cyc(input bit ea, input bit wa, input bit sa, input logic [7:0] aa,
                       input logic [17:0] da, input bit eb, input bit wb, input bit sb,
                       input logic [7:0] ab, input logic [17:0] db, input string tg);
        logic [17:0] o1a, o1b, o2a, o2b;
        bit ov1a, ov1b, ov2a, ov2b;
        string t1a, t1b, t2a, t2b;
        en_a = ea; we_a = wa; srst_a = sa; addr_a = aa; din_a = da[15:0]; dinp_a = da[17:16];
        en_b = eb; we_b = wb; srst_b = sb; addr_b = ab; din_b = db[15:0]; dinp_b = db[17:16];
        o1a = m1[aa]; ov1a = v1[aa]; o1b = m1[ab]; ov1b = v1[ab];
        o2a = m2[aa[3:0]]; ov2a = v2[aa[3:0]]; o2b = m2[ab[3:0]]; ov2b = v2[ab[3:0]];
        model_port(WF, ea, wa, sa, da, o1a, ov1a, RST1A, e1a, ev1a);
        model_port(RF, eb, wb, sb, db, o1b, ov1b, RST1B, e1b, ev1b);
        model_port(NC, ea, wa, sa, {14'd0, da[3:0]}, o2a, ov2a, RST2A, e2a, ev2a);
        model_port(WF, eb, wb, sb, {14'd0, db[3:0]}, o2b, ov2b, RST2B, e2b, ev2b);
        if (ea && wa) begin m1[aa] = da; v1[aa] = 1; m2[aa[3:0]] = {14'd0, da[3:0]}; v2[aa[3:0]] = 1; end
        if (eb && wb) begin m1[ab] = db; v1[ab] = 1; m2[ab[3:0]] = {14'd0, db[3:0]}; v2[ab[3:0]] = 1; end
        t1a = (tg != "") ? tg : tag_for(WF, ea, wa, sa);
        t1b = (tg != "") ? tg : tag_for(RF, eb, wb, sb);
        t2a = (tg != "") ? tg : tag_for(NC, ea, wa, sa);
        t2b = (tg != "") ? tg : tag_for(WF, eb, wb, sb);
        @(negedge clk);
        if (ev1a) chk(t1a, "wide A", {doutp1_a, dout1_a}, e1a);
        if (ev1b) chk(t1b, "wide B", {doutp1_b, dout1_b}, e1b);
        if (ev2a) chk(t2a, "narrow A", {14'd0, dout2_a}, e2a);
        if (ev2b) chk(t2b, "narrow B", {14'd0, dout2_b}, e2b);
        chk("R10", "narrow parity", {16'd0, doutp2_a, doutp2_b}, 18'd0);
    endtask

    function automatic logic [17:0] rword();
        return {$urandom} & 18'h3FFFF;
    endfunction

    initial begin
        #1;
        // R9: power-up output values
        chk("R9", "wide A", {doutp1_a, dout1_a}, RST1A);
        chk("R9", "wide B", {doutp1_b, dout1_b}, RST1B);
        chk("R9", "narrow A", {14'd0, dout2_a}, RST2A);
        chk("R9", "narrow B", {14'd0, dout2_b}, RST2B);
        void'($urandom(32'd20240611));
        @(negedge clk);
        // fill every location; port B address never shares low bits with port A
        for (int i = 0; i < 128; i++) begin
            cyc(1, 1, 0, 8'(i), rword(), 1, 1, 0, 8'(128 + ((i + 8) & 127)), rword(), "");
        end
        // R2: write on A, read back on B (and vice versa)
        cyc(1, 1, 0, 8'h33, 18'h2BEEF, 0, 0, 0, 8'h00, 18'h0, "R2");
        cyc(0, 0, 0, 8'h00, 18'h0, 1, 0, 0, 8'h33, 18'h0, "R2");
        cyc(0, 0, 0, 8'h00, 18'h0, 1, 1, 0, 8'h47, 18'h1C0DE, "R2");
        cyc(1, 0, 0, 8'h47, 18'h0, 0, 0, 0, 8'h00, 18'h0, "R2");
        // R8: force and write together, then read back the stored word
        cyc(1, 1, 1, 8'h52, 18'h3A5A5, 1, 1, 1, 8'h6D, 18'h05A5A, "R8");
        cyc(1, 0, 0, 8'h6D, 18'h0, 1, 0, 0, 8'h52, 18'h0, "R8");
        // R7: force on A only, B reading; then read A's address to see contents kept
        cyc(1, 0, 1, 8'h10, 18'h0, 1, 0, 0, 8'h21, 18'h0, "R7");
        cyc(1, 0, 0, 8'h10, 18'h0, 1, 0, 1, 8'h21, 18'h0, "R7");
        // R6: disabled edges with write and force high, then readback
        cyc(0, 1, 1, 8'h10, 18'h12345, 0, 1, 1, 8'h21, 18'h2ABCD, "R6");
        cyc(1, 0, 0, 8'h21, 18'h0, 1, 0, 0, 8'h10, 18'h0, "R6");
        // R5/R3/R4: back-to-back writes to observe each mode
        cyc(1, 1, 0, 8'h05, 18'h0F00F, 1, 1, 0, 8'h0A, 18'h30FF0, "");
        cyc(1, 1, 0, 8'h05, 18'h1111E, 1, 1, 0, 8'h0A, 18'h22221, "");
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            bit ea, wa, sa, eb, wb, sb;
            logic [7:0] aa, ab;
            ea = ($urandom % 10) < 8; wa = $urandom % 2; sa = ($urandom % 10) == 0;
            eb = ($urandom % 10) < 8; wb = $urandom % 2; sb = ($urandom % 10) == 0;
            aa = 8'($urandom); ab = 8'($urandom);
            if (aa[3:0] == ab[3:0]) ab[3:0] = aa[3:0] ^ 4'(1 + $urandom % 15);
            cyc(ea, wa, sa, aa, rword(), eb, wb, sb, ab, rword(), "");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule